// File: doc/BRIEF.md
# Store Assumption Watch Unit

This unit sits beside a processor datapath and watches every store. Compiled code may rely on a protected address window never being written, or a debugger may want to know when a particular address is touched. A store that breaks one of these assumptions is a violation. The unit checks each store against one inclusive address window and a small bank of single-address comparators. Each comparator has its own enable bit.

Configuration selects one of two responses to a violation. In trap mode, a synchronous exception request is raised together with a vector code that names the comparator that fired. The request is held until the handler acknowledges it. In poison mode, nothing is raised. Instead, per-source sticky dirty flags mark computed results as untrustworthy. The offending store is inhibited combinationally, in the same cycle it is presented. Every later store stays inhibited until software clears the flags. A status record keeps the comparator bitmap and the address of the most recent violating store.

Top module: `store_watch`

## Requirements
- R1: After reset every output is low or zero, both modes are off, and no comparator is enabled.
- R2: A configuration write (cfg_we_i) takes effect from the next cycle. The slot map is: 0 = window low bound, 1 = window high bound, 2 = control, 3 = unused (writes are ignored), 4+k = watch address k. The control field is: bit 0 enables the window; bit k+1 enables watch k; bit NUM_WATCH+1 (bit 5 by default) selects poison mode when 1 and trap mode when 0.
- R3: The window matches an address a only when it is enabled and low <= a <= high, with both bounds included. A window with low > high never matches.
- R4: Watch comparator k matches only when its enable bit is set and the store address equals watch address k exactly.
- R5: In trap mode, a valid store that hits raises exc_req_o on the next cycle. The vector code is the lowest-numbered hitting source: the window is 0 and watch k is k+1. The request stays high until exc_ack_i is seen. A hit in the same cycle as an acknowledge raises a fresh request carrying the new vector.
- R6: While a request is pending and not being acknowledged, further hits leave both the request and its vector unchanged.
- R7: In poison mode, a valid hitting store ORs its source bitmap into dirty_o (bit 0 = window, bit k+1 = watch k) on the next cycle. No exception request is raised. Dirty bits hold until poison_clr_i. A hit in the same cycle as the clear still sets its bits.
- R8: In poison mode, st_block_o is high combinationally during any cycle where a valid store hits.
- R9: In poison mode, while any dirty bit is set, st_block_o is also high for every valid store, whether or not it hits. In trap mode st_block_o is always low.
- R10: On every valid hitting store, in either mode, stat_src_o and stat_addr_o capture the hit bitmap and the address on the next cycle, and stat_valid_o goes high. poison_clr_i clears stat_valid_o unless a hit arrives in the same cycle.
- R11: With st_valid_i low, no address causes a block, a request, a dirty bit or a status update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| st_valid_i | input | 1 | Store presented this cycle |
| st_addr_i | input | AW | Store address |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | CFG_IW | Configuration slot select |
| cfg_data_i | input | AW | Configuration write data |
| exc_ack_i | input | 1 | Handler acknowledges the pending request |
| poison_clr_i | input | 1 | Clears dirty flags and status valid |
| st_block_o | output | 1 | Inhibit the current store (combinational) |
| exc_req_o | output | 1 | Synchronous exception request |
| exc_vec_o | output | VEC_W | Vector code of the pending request |
| dirty_o | output | NUM_WATCH+1 | Sticky per-source dirty flags |
| stat_valid_o | output | 1 | Status record holds a violation |
| stat_src_o | output | NUM_WATCH+1 | Hit bitmap of the last violation |
| stat_addr_o | output | AW | Address of the last violation |

## Verification
Two pairs of events can land in the same cycle: an acknowledge arriving together with a new trap-mode hit, and a dirty-flag clear arriving together with a new poison-mode hit. Directed cycles force both pairs. The random phase drives acknowledge and clear strobes independently of hits, so both pairs recur many times. In each case the bench expects the new violation to survive, with the new vector in the request or the new bits in the dirty flags and status. A configuration write in the same cycle as a store is also exercised, and the store must be judged against the old settings.

// File: rtl/watch_pkg.sv
package watch_pkg;
  localparam int unsigned SLOT_LO     = 0;
  localparam int unsigned SLOT_HI     = 1;
  localparam int unsigned SLOT_CTRL   = 2;
  localparam int unsigned SLOT_WATCH0 = 4;

  typedef enum logic {
    RESP_TRAP   = 1'b0,
    RESP_POISON = 1'b1
  } resp_mode_e;
endpackage

// File: rtl/range_cmp.sv
module range_cmp #(
  parameter int unsigned AW = 32
) (
  input  logic          en_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  logic ge_lo, le_hi;

  assign ge_lo = (addr_i >= lo_i);
  assign le_hi = (addr_i <= hi_i);
  // an inverted window cannot satisfy both compares
  assign hit_o = en_i & ge_lo & le_hi;
endmodule

// File: rtl/watch_bank.sv
module watch_bank #(
  parameter int unsigned AW = 32,
  parameter int unsigned N  = 4
) (
  input  logic [N-1:0][AW-1:0] addr_tbl_i,
  input  logic [N-1:0]         en_i,
  input  logic [AW-1:0]        addr_i,
  output logic [N-1:0]         hit_o
);
  for (genvar k = 0; k < N; k++) begin : g_cmp
    assign hit_o[k] = en_i[k] & (addr_tbl_i[k] == addr_i);
  end
endmodule

// File: rtl/viol_resp.sv
module viol_resp #(
  parameter int unsigned AW    = 32,
  parameter int unsigned NSRC  = 5,
  parameter int unsigned VEC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             st_valid_i,
  input  logic [AW-1:0]    st_addr_i,
  input  logic [NSRC-1:0]  hit_i,
  input  logic             poison_i,
  input  logic             exc_ack_i,
  input  logic             poison_clr_i,
  output logic             st_block_o,
  output logic             exc_req_o,
  output logic [VEC_W-1:0] exc_vec_o,
  output logic [NSRC-1:0]  dirty_o,
  output logic             stat_valid_o,
  output logic [NSRC-1:0]  stat_src_o,
  output logic [AW-1:0]    stat_addr_o
);
  logic             any_hit;
  logic [VEC_W-1:0] enc;
  logic             req_q;
  logic [VEC_W-1:0] vec_q;
  logic [NSRC-1:0]  dirty_q, src_q;
  logic             sv_q;
  logic [AW-1:0]    addr_q;

  assign any_hit = st_valid_i & (|hit_i);

  // lowest source index wins
  always_comb begin
    enc = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (hit_i[i]) enc = VEC_W'(i);
    end
  end

  // combinational so the store is stopped before it commits
  assign st_block_o = st_valid_i & poison_i & ((|hit_i) | (|dirty_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else begin
      if (exc_ack_i) req_q <= 1'b0;
      if (any_hit && !poison_i && (!req_q || exc_ack_i)) begin
        req_q <= 1'b1;
        vec_q <= enc;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dirty_q <= '0;
      sv_q    <= 1'b0;
      src_q   <= '0;
      addr_q  <= '0;
    end else begin
      dirty_q <= (poison_clr_i ? '0 : dirty_q) |
                 ((any_hit && poison_i) ? hit_i : '0);
      sv_q    <= (poison_clr_i ? 1'b0 : sv_q) | any_hit;
      if (any_hit) begin
        src_q  <= hit_i;
        addr_q <= st_addr_i;
      end
    end
  end

  assign exc_req_o    = req_q;
  assign exc_vec_o    = vec_q;
  assign dirty_o      = dirty_q;
  assign stat_valid_o = sv_q;
  assign stat_src_o   = src_q;
  assign stat_addr_o  = addr_q;

  assert_block_needs_store_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_block_o |-> st_valid_i);
  assert_req_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o && !exc_ack_i |=> exc_req_o);
  assert_vec_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o && !exc_ack_i |=> $stable(exc_vec_o));
  assert_dirty_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !poison_clr_i |=> ((dirty_o & $past(dirty_o)) == $past(dirty_o)));
  assert_trap_keeps_dirty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !poison_i && !poison_clr_i |=> $stable(dirty_o));
  assert_poison_no_trap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poison_i && !exc_req_o |=> !exc_req_o);
  assert_idle_no_status_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_valid_i |=> $stable(stat_addr_o) && $stable(stat_src_o));
endmodule

// File: rtl/store_watch.sv
module store_watch
  import watch_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned NUM_WATCH = 4,
  localparam int unsigned NSRC     = NUM_WATCH + 1,
  localparam int unsigned VEC_W    = $clog2(NSRC),
  localparam int unsigned CFG_IW   = $clog2(SLOT_WATCH0 + NUM_WATCH),
  localparam int unsigned CTRL_W   = NUM_WATCH + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_valid_i,
  input  logic [AW-1:0]     st_addr_i,
  input  logic              cfg_we_i,
  input  logic [CFG_IW-1:0] cfg_idx_i,
  input  logic [AW-1:0]     cfg_data_i,
  input  logic              exc_ack_i,
  input  logic              poison_clr_i,
  output logic              st_block_o,
  output logic              exc_req_o,
  output logic [VEC_W-1:0]  exc_vec_o,
  output logic [NSRC-1:0]   dirty_o,
  output logic              stat_valid_o,
  output logic [NSRC-1:0]   stat_src_o,
  output logic [AW-1:0]     stat_addr_o
);
  logic [AW-1:0]                lo_q, hi_q;
  logic [CTRL_W-1:0]            ctrl_q;
  logic [NUM_WATCH-1:0][AW-1:0] watch_q;
  logic                         rng_hit;
  logic [NUM_WATCH-1:0]         w_hit;
  resp_mode_e                   mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= '0;
      hi_q    <= '0;
      ctrl_q  <= '0;
      watch_q <= '0;
    end else if (cfg_we_i) begin
      if (cfg_idx_i == CFG_IW'(SLOT_LO))   lo_q   <= cfg_data_i;
      if (cfg_idx_i == CFG_IW'(SLOT_HI))   hi_q   <= cfg_data_i;
      if (cfg_idx_i == CFG_IW'(SLOT_CTRL)) ctrl_q <= cfg_data_i[CTRL_W-1:0];
      for (int k = 0; k < NUM_WATCH; k++) begin
        if (cfg_idx_i == CFG_IW'(SLOT_WATCH0 + k)) watch_q[k] <= cfg_data_i;
      end
    end
  end

  assign mode = resp_mode_e'(ctrl_q[CTRL_W-1]);

  range_cmp #(.AW(AW)) u_range (
    .en_i   (ctrl_q[0]),
    .lo_i   (lo_q),
    .hi_i   (hi_q),
    .addr_i (st_addr_i),
    .hit_o  (rng_hit)
  );

  watch_bank #(.AW(AW), .N(NUM_WATCH)) u_watch (
    .addr_tbl_i (watch_q),
    .en_i       (ctrl_q[NUM_WATCH:1]),
    .addr_i     (st_addr_i),
    .hit_o      (w_hit)
  );

  viol_resp #(.AW(AW), .NSRC(NSRC), .VEC_W(VEC_W)) u_resp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .st_valid_i   (st_valid_i),
    .st_addr_i    (st_addr_i),
    .hit_i        ({w_hit, rng_hit}),
    .poison_i     (mode == RESP_POISON),
    .exc_ack_i    (exc_ack_i),
    .poison_clr_i (poison_clr_i),
    .st_block_o   (st_block_o),
    .exc_req_o    (exc_req_o),
    .exc_vec_o    (exc_vec_o),
    .dirty_o      (dirty_o),
    .stat_valid_o (stat_valid_o),
    .stat_src_o   (stat_src_o),
    .stat_addr_o  (stat_addr_o)
  );

  assert_trap_never_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == RESP_TRAP) |-> !st_block_o);
  assert_empty_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_q > hi_q) && st_valid_i && (w_hit == '0) |=> $stable(stat_addr_o) || !$past(rng_hit));
endmodule

// File: tb/store_watch_test.sv
module store_watch_test;
  localparam int AW = 32;
  localparam int NW = 4;
  localparam int NS = NW + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          st_v = 1'b0;
  logic [AW-1:0] st_a = '0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_idx = '0;
  logic [AW-1:0] cfg_d = '0;
  logic          ack = 1'b0;
  logic          clr = 1'b0;
  logic          blk, req, sv;
  logic [2:0]    vec;
  logic [NS-1:0] dirty, src;
  logic [AW-1:0] saddr;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference state
  logic [AW-1:0] m_lo, m_hi;
  logic [5:0]    m_ctrl;
  logic [AW-1:0] m_w [NW];
  logic          m_req, m_sv;
  logic [2:0]    m_vec;
  logic [NS-1:0] m_dirty, m_src;
  logic [AW-1:0] m_addr;
  string         tag;

  always #10 clk = ~clk;

  store_watch #(.AW(AW), .NUM_WATCH(NW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .st_valid_i(st_v), .st_addr_i(st_a),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_d),
    .exc_ack_i(ack), .poison_clr_i(clr), .st_block_o(blk),
    .exc_req_o(req), .exc_vec_o(vec), .dirty_o(dirty),
    .stat_valid_o(sv), .stat_src_o(src), .stat_addr_o(saddr)
  );

  function automatic logic [NS-1:0] hits(logic [AW-1:0] a);
    logic [NS-1:0] h;
    h[0] = m_ctrl[0] && (m_lo <= m_hi) && (a >= m_lo) && (a <= m_hi);
    for (int k = 0; k < NW; k++) h[k+1] = m_ctrl[k+1] && (a == m_w[k]);
    return h;
  endfunction

  function automatic logic [2:0] lowest(logic [NS-1:0] h);
    for (int i = 0; i < NS; i++) if (h[i]) return 3'(i);
    return 3'd0;
  endfunction

  task automatic chk(string req_tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (%s): actual %h expected %h at %0t", req_tag, tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_lo = '0; m_hi = '0; m_ctrl = '0;
    for (int k = 0; k < NW; k++) m_w[k] = '0;
    m_req = 0; m_sv = 0; m_vec = '0; m_dirty = '0; m_src = '0; m_addr = '0;
  endtask

  // one cycle: drive after negedge, check block mid-low, update, check after posedge
  task automatic step(logic v, logic [AW-1:0] a, logic we, logic [2:0] idx,
                      logic [AW-1:0] d, logic ak, logic cl);
    logic [NS-1:0] h;
    logic          poison, hit;
    st_v = v; st_a = a; cfg_we = we; cfg_idx = idx; cfg_d = d; ack = ak; clr = cl;
    #5;
    h = hits(a);
    poison = m_ctrl[5];
    hit = v && (h != '0);
    chk("R8/R9 block", 64'(blk), 64'(v && poison && ((h != '0) || (m_dirty != '0))));
    @(posedge clk);
    if (ak) m_req = 0;
    if (hit && !poison && (!m_req || ak)) begin m_req = 1; m_vec = lowest(h); end
    m_dirty = (cl ? '0 : m_dirty) | ((hit && poison) ? h : '0);
    m_sv = (cl ? 1'b0 : m_sv) | hit;
    if (hit) begin m_src = h; m_addr = a; end
    if (we) begin
      case (idx)
        3'd0: m_lo = d;
        3'd1: m_hi = d;
        3'd2: m_ctrl = d[5:0];
        3'd3: ;
        default: m_w[idx-4] = d;
      endcase
    end
    #1;
    chk("R5 req", 64'(req), 64'(m_req));
    if (m_req) chk("R5/R6 vector", 64'(vec), 64'(m_vec));
    chk("R7 dirty", 64'(dirty), 64'(m_dirty));
    chk("R10 status valid", 64'(sv), 64'(m_sv));
    if (m_sv) begin
      chk("R10 status src", 64'(src), 64'(m_src));
      chk("R10 status addr", 64'(saddr), 64'(m_addr));
    end
    @(negedge clk);
  endtask

  task automatic cfg(logic [2:0] idx, logic [AW-1:0] d);
    step(0, '0, 1, idx, d, 0, 0);
  endtask

  task automatic st(logic [AW-1:0] a);
    step(1, a, 0, 0, '0, 0, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    model_reset();
    tag = "R1";
    #35; rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 block", 64'(blk), 0);
    chk("R1 req", 64'(req), 0);
    chk("R1 dirty", 64'(dirty), 0);
    chk("R1 status", 64'({sv, src, saddr}), 0);
    // R1: nothing enabled, store anywhere is harmless
    st(32'h0); st(32'h100);

    // R2: slot map; slot 3 write ignored
    tag = "R2";
    cfg(0, 32'h100); cfg(1, 32'h1FF); cfg(3, 32'h3F);
    st(32'h150);               // ctrl still 0 -> no hit
    cfg(2, 32'h01);            // window enable, trap mode

    // R3: inclusive bounds
    tag = "R3";
    st(32'h0FF); st(32'h100);
    step(1, 32'h1FF, 0, 0, '0, 1, 0);   // ack with hit -> new request
    step(0, '0, 0, 0, '0, 1, 0);
    st(32'h200);
    cfg(0, 32'h300); cfg(1, 32'h2FF);   // inverted window
    st(32'h300); st(32'h2FF);

    // R4: watches, only 1 and 3 enabled
    tag = "R4";
    cfg(4, 32'h400); cfg(5, 32'h401); cfg(6, 32'h402); cfg(7, 32'h403);
    cfg(2, 32'h14);
    st(32'h400); st(32'h402); st(32'h401);
    // R6: pending request keeps vector
    tag = "R6";
    st(32'h403); st(32'h401);
    // R5: ack and new hit in same cycle
    tag = "R5";
    step(1, 32'h403, 0, 0, '0, 1, 0);
    step(0, '0, 0, 0, '0, 1, 0);
    // R11: strobe low
    tag = "R11";
    step(0, 32'h401, 0, 0, '0, 0, 0);
    step(0, 32'h403, 0, 0, '0, 0, 0);

    // R7/R8/R9: poison mode
    tag = "R7";
    cfg(0, 32'h100); cfg(1, 32'h1FF); cfg(2, 32'h3F);
    st(32'h050);               // clean store passes
    st(32'h401);               // blocked, dirty bit 2
    tag = "R9";
    st(32'h050);               // blocked by sticky dirty
    step(0, 32'h401, 0, 0, '0, 0, 0);   // R11 in poison mode
    tag = "R7";
    step(1, 32'h180, 0, 0, '0, 0, 1);   // clear with hit: bit 0 survives
    step(0, '0, 0, 0, '0, 0, 1);
    st(32'h050);               // now passes
    // R9: trap mode never blocks even with dirty set
    st(32'h120);
    cfg(2, 32'h1F);
    st(32'h050); st(32'h120);
    step(0, '0, 0, 0, '0, 1, 1);

    // random phase
    tag = "rand";
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      logic          we;
      logic [2:0]    idx;
      logic [AW-1:0] d;
      case ($urandom_range(0, 2))
        0: a = 32'h400 + 32'($urandom_range(0, 4));
        default: a = 32'h0F0 + 32'($urandom_range(0, 96));
      endcase
      we = ($urandom_range(0, 15) == 0);
      idx = 3'($urandom_range(0, 7));
      if (idx == 3'd2) d = 32'($urandom_range(0, 63));
      else if (idx >= 3'd4) d = 32'h400 + 32'($urandom_range(0, 4));
      else d = 32'h0F0 + 32'($urandom_range(0, 96));
      step($urandom_range(0, 3) != 0, a, we, idx, d,
           $urandom_range(0, 3) == 0, $urandom_range(0, 9) == 0);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule